// File: doc/BRIEF.md
# Macroblock Side-Information Output Formatter

This block takes the header fields of one macroblock from a block-based video encoder and sends them out one byte per cycle on an 8-bit bus. The header fields are the group number, the macroblock number, six per-sub-block coded flags, a quantiser code, a motion-compensation flag and two motion-vector components. Each byte comes with a 4-bit mode tag that names the field it carries, and with a data-valid strobe. Every field sits at fixed bit positions. Every bus bit that the current field does not use is driven low.

A producer raises `start_i` for one cycle while `ready_o` is high. All field inputs are captured on that edge. The block then sends the bytes in this order:

1. group number
2. macroblock number
3. control decisions
4. coded pattern
5. quantiser
6. horizontal vector, then vertical vector (only when motion compensation is used)

The consumer holds the sequence by pulling `dready_i` low. Each such cycle becomes a wait state. The block also works out the fixed-macroblock decision and reports it in the control-decisions byte.

Top module: `mb_hdr_fmt`

## Requirements
- R1: Out of reset, and whenever no header is in progress, `ready_o`=1, `dvalid_o`=0, `dmode_o`=15 and `dbus_o`=0.
- R2: The first byte after an accepted start carries mode tag 0 and the group number on bits 3:0 (bit 3 MSB). Bits 7:4 are 0.
- R3: The second byte carries tag 1 and the macroblock number on bits 5:0 (bit 5 MSB). Bits 7:6 are 0.
- R4: The third byte carries tag 2 and is the control-decisions byte. Bit 1 is the motion-compensation flag and bits 7:2 are 0.
- R5: Bit 0 of the control-decisions byte (the fixed-macroblock flag) is 1 exactly when motion compensation is off and all six coded flags are 0.
- R6: The fourth byte carries tag 3. Its bit 7-k is set when sub-block k (1..6, `coded_i[k-1]`) is coded, so sub-block 1 maps to bit 6 and sub-block 6 maps to bit 1. Bits 7 and 0 are 0.
- R7: The fifth byte carries tag 4 and the quantiser code on bits 4:0, where the actual level is twice the code. Bits 7:5 are 0.
- R8: With motion compensation on, two more bytes follow the quantiser: tag 5 with the horizontal vector and then tag 6 with the vertical vector. Each is a 5-bit two's-complement value on bits 4:0 with bits 7:5 at 0. With motion compensation off, the quantiser byte is the last byte.
- R9: A cycle with `dready_i`=0 during a header is a wait state: `dvalid_o`=0, `dmode_o`=15, `dbus_o`=0. The pending byte is presented unchanged in the next cycle that has `dready_i`=1.
- R10: `ready_o` drops in the cycle after an accepted start and rises again only in the cycle after the last byte transfer. A `start_i` pulse or a change of field inputs while busy has no effect on the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a header; accepted when `ready_o` is high |
| gob_i | input | 4 | Group number |
| mb_i | input | 6 | Macroblock number |
| coded_i | input | 6 | Coded flag per sub-block; bit 0 = sub-block 1 |
| quant_i | input | 5 | Quantiser code (level = 2 x code) |
| mc_i | input | 1 | Motion compensation used |
| mvh_i | input | 5 | Horizontal vector, two's complement |
| mvv_i | input | 5 | Vertical vector, two's complement |
| dready_i | input | 1 | Downstream can take a byte this cycle |
| ready_o | output | 1 | Idle; a new start is accepted |
| dvalid_o | output | 1 | Byte on `dbus_o` is valid this cycle |
| dmode_o | output | 4 | Field tag of the current byte; 15 = wait |
| dbus_o | output | 8 | Output byte |

## Verification
The bench builds the formatter with its default widths: an 8-bit bus, six sub-blocks, 5-bit quantiser and vector fields, a 4-bit group number and a 6-bit macroblock number. These widths let the bench hit the extreme codes directly, including all-ones group and macroblock numbers, vectors of -16 and +15, and single coded sub-blocks at both ends of the pattern byte. The bench also runs headers with and without motion compensation, stalls the output in the middle of a header, and pulses start while the block is busy.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  typedef enum logic [3:0] {
    F_GOB  = 4'd0,
    F_MB   = 4'd1,
    F_CTRL = 4'd2,
    F_CBP  = 4'd3,
    F_QNT  = 4'd4,
    F_MVH  = 4'd5,
    F_MVV  = 4'd6,
    F_WAIT = 4'd15
  } field_e;
endpackage

// File: rtl/mbf_seq.sv
module mbf_seq
  import mbf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   mc_i,
  input  logic   dready_i,
  output logic   accept_o,
  output logic   xfer_o,
  output logic   busy_o,
  output field_e tag_o
);
  logic   busy_q;
  field_e tag_q;

  assign accept_o = start_i && !busy_q;
  assign xfer_o   = busy_q && dready_i;
  assign busy_o   = busy_q;
  assign tag_o    = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tag_q  <= F_GOB;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      tag_q  <= F_GOB;
    end else if (xfer_o) begin
      unique case (tag_q)
        F_GOB:  tag_q <= F_MB;
        F_MB:   tag_q <= F_CTRL;
        F_CTRL: tag_q <= F_CBP;
        F_CBP:  tag_q <= F_QNT;
        F_QNT: begin
          if (mc_i) tag_q <= F_MVH;
          else      busy_q <= 1'b0;
        end
        F_MVH:  tag_q <= F_MVV;
        default: busy_q <= 1'b0;
      endcase
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !dready_i |=> busy_q && $stable(tag_q));

  // R8
  mv_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && tag_q == F_QNT && !mc_i |=> !busy_q);

  // R8
  mv_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && tag_q == F_MVH |=> busy_q && tag_q == F_MVV);
endmodule

// File: rtl/mbf_cbp.sv
module mbf_cbp #(
  parameter int NSUB  = 6,
  parameter int BUS_W = 8
) (
  input  logic [NSUB-1:0]  coded_i,
  output logic [BUS_W-1:0] byte_o
);
  // sub-block k+1 lands on bit NSUB-k; bit 0 and bits above NSUB stay low
  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    if (b >= 1 && b <= NSUB) begin : g_map
      assign byte_o[b] = coded_i[NSUB-b];
    end else begin : g_zero
      assign byte_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/mbf_pack.sv
module mbf_pack
  import mbf_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int GOB_W = 4,
  parameter int MB_W  = 6,
  parameter int NSUB  = 6,
  parameter int Q_W   = 5,
  parameter int MV_W  = 5
) (
  input  logic             valid_i,
  input  field_e           tag_i,
  input  logic [GOB_W-1:0] gob_i,
  input  logic [MB_W-1:0]  mb_i,
  input  logic [NSUB-1:0]  coded_i,
  input  logic [Q_W-1:0]   quant_i,
  input  logic             mc_i,
  input  logic [MV_W-1:0]  mvh_i,
  input  logic [MV_W-1:0]  mvv_i,
  output logic             dvalid_o,
  output logic [3:0]       dmode_o,
  output logic [BUS_W-1:0] dbus_o
);
  logic [BUS_W-1:0] cbp_byte;
  logic             fixed_mb;

  mbf_cbp #(.NSUB(NSUB), .BUS_W(BUS_W)) u_cbp (
    .coded_i(coded_i),
    .byte_o (cbp_byte)
  );

  assign fixed_mb = !mc_i && (coded_i == '0);

  always_comb begin
    dvalid_o = valid_i;
    dmode_o  = valid_i ? 4'(tag_i) : 4'(F_WAIT);
    dbus_o   = '0;
    if (valid_i) begin
      unique case (tag_i)
        F_GOB:  dbus_o[GOB_W-1:0] = gob_i;
        F_MB:   dbus_o[MB_W-1:0]  = mb_i;
        F_CTRL: dbus_o[1:0]       = {mc_i, fixed_mb};
        F_CBP:  dbus_o            = cbp_byte;
        F_QNT:  dbus_o[Q_W-1:0]   = quant_i;
        F_MVH:  dbus_o[MV_W-1:0]  = mvh_i;
        F_MVV:  dbus_o[MV_W-1:0]  = mvv_i;
        default: dbus_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mb_hdr_fmt.sv
module mb_hdr_fmt
  import mbf_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int GOB_W = 4,
  parameter int MB_W  = 6,
  parameter int NSUB  = 6,
  parameter int Q_W   = 5,
  parameter int MV_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [GOB_W-1:0] gob_i,
  input  logic [MB_W-1:0]  mb_i,
  input  logic [NSUB-1:0]  coded_i,
  input  logic [Q_W-1:0]   quant_i,
  input  logic             mc_i,
  input  logic [MV_W-1:0]  mvh_i,
  input  logic [MV_W-1:0]  mvv_i,
  input  logic             dready_i,
  output logic             ready_o,
  output logic             dvalid_o,
  output logic [3:0]       dmode_o,
  output logic [BUS_W-1:0] dbus_o
);
  logic             accept, xfer, busy;
  field_e           tag;
  logic [GOB_W-1:0] gob_q;
  logic [MB_W-1:0]  mb_q;
  logic [NSUB-1:0]  coded_q;
  logic [Q_W-1:0]   quant_q;
  logic             mc_q;
  logic [MV_W-1:0]  mvh_q, mvv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gob_q <= '0; mb_q <= '0; coded_q <= '0; quant_q <= '0;
      mc_q  <= 1'b0; mvh_q <= '0; mvv_q <= '0;
    end else if (accept) begin
      gob_q <= gob_i; mb_q <= mb_i; coded_q <= coded_i; quant_q <= quant_i;
      mc_q  <= mc_i;  mvh_q <= mvh_i; mvv_q <= mvv_i;
    end
  end

  mbf_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mc_i    (mc_q),
    .dready_i(dready_i),
    .accept_o(accept),
    .xfer_o  (xfer),
    .busy_o  (busy),
    .tag_o   (tag)
  );

  assign ready_o = !busy;

  mbf_pack #(
    .BUS_W(BUS_W), .GOB_W(GOB_W), .MB_W(MB_W),
    .NSUB(NSUB), .Q_W(Q_W), .MV_W(MV_W)
  ) u_pack (
    .valid_i (xfer),
    .tag_i   (tag),
    .gob_i   (gob_q),
    .mb_i    (mb_q),
    .coded_i (coded_q),
    .quant_i (quant_q),
    .mc_i    (mc_q),
    .mvh_i   (mvh_q),
    .mvv_i   (mvv_q),
    .dvalid_o(dvalid_o),
    .dmode_o (dmode_o),
    .dbus_o  (dbus_o)
  );

  // R10
  start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && ready_o |=> !ready_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !dvalid_o && dmode_o == 4'(F_WAIT) && dbus_o == '0);

  // R9
  wait_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dready_i |-> !dvalid_o && dmode_o == 4'(F_WAIT));

  // R6
  cbp_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && dmode_o == 4'(F_CBP) |-> !dbus_o[BUS_W-1] && !dbus_o[0]);

  // R5
  fixed_mb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && dmode_o == 4'(F_CTRL) |-> dbus_o[0] == (!mc_q && coded_q == '0));

  // R2
  gob_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && dmode_o == 4'(F_GOB) |-> dbus_o[BUS_W-1:GOB_W] == '0);
endmodule

// File: tb/mb_hdr_fmt_tb_top.sv
module mb_hdr_fmt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {gob[4], mb[6], coded[6], quant[5], mc, mvh[5], mvv[5]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd1,  6'd1,  6'b111111, 5'd1,  1'b1, 5'h1F, 5'h07},
    {4'd15, 6'd33, 6'b000000, 5'd31, 1'b0, 5'h03, 5'h02},
    {4'd5,  6'd63, 6'b000001, 5'd10, 1'b0, 5'h00, 5'h00},
    {4'd0,  6'd0,  6'b000000, 5'd2,  1'b1, 5'h10, 5'h0F},
    {4'd12, 6'd20, 6'b100000, 5'd16, 1'b1, 5'h08, 5'h18},
    {4'd3,  6'd7,  6'b010101, 5'd0,  1'b0, 5'h0A, 5'h15}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mc = 1'b0, dready = 1'b1;
  logic [3:0] gob = '0;
  logic [5:0] mb = '0, coded = '0;
  logic [4:0] quant = '0, mvh = '0, mvv = '0;
  logic ready, dvalid;
  logic [3:0] dmode;
  logic [7:0] dbus;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mb_hdr_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gob_i(gob), .mb_i(mb),
    .coded_i(coded), .quant_i(quant), .mc_i(mc), .mvh_i(mvh), .mvv_i(mvv),
    .dready_i(dready), .ready_o(ready), .dvalid_o(dvalid), .dmode_o(dmode),
    .dbus_o(dbus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {ready, dvalid, dmode, dbus}, {1'b1, 1'b0, 4'd15, 8'd0});
  endtask

  // stall: hold off byte 2; poke: pulse start with other fields while busy
  task automatic run_mb(input logic [31:0] v, input bit stall, input bit poke);
    logic [3:0] e_mode [7];
    logic [7:0] e_bus [7];
    int n;
    logic [5:0] cd;
    cd = v[21:16];
    e_mode[0] = 0; e_bus[0] = {4'd0, v[31:28]};
    e_mode[1] = 1; e_bus[1] = {2'd0, v[27:22]};
    e_mode[2] = 2; e_bus[2] = {6'd0, v[10], (!v[10] && cd == 0)};
    e_mode[3] = 3; e_bus[3] = '0;
    for (int k = 0; k < 6; k++) if (cd[k]) e_bus[3][6-k] = 1'b1;
    e_mode[4] = 4; e_bus[4] = {3'd0, v[15:11]};
    e_mode[5] = 5; e_bus[5] = {3'd0, v[9:5]};
    e_mode[6] = 6; e_bus[6] = {3'd0, v[4:0]};
    n = v[10] ? 7 : 5;
    @(negedge clk);
    {gob, mb, coded, quant, mc, mvh, mvv} = v;
    start = 1'b1; dready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 ready low after start", ready, 0);
    for (int i = 0; i < n; i++) begin
      if (poke && i == 1) begin
        start = 1'b1; {gob, mb, coded, quant, mc, mvh, mvv} = ~v;
      end
      if (stall && i == 2) begin
        dready = 1'b0; #1;
        chk("R9 wait state", {dvalid, dmode, dbus}, {1'b0, 4'd15, 8'd0});
        @(negedge clk);
        chk("R9 wait state held", {dvalid, dmode, dbus}, {1'b0, 4'd15, 8'd0});
        dready = 1'b1;
      end
      #1;
      case (i)
        0: chk("R2 gob byte", {dvalid, dmode, dbus}, {1'b1, e_mode[i], e_bus[i]});
        1: chk("R3 mb byte", {dvalid, dmode, dbus}, {1'b1, e_mode[i], e_bus[i]});
        2: chk("R4 R5 ctrl byte", {dvalid, dmode, dbus}, {1'b1, e_mode[i], e_bus[i]});
        3: chk("R6 cbp byte", {dvalid, dmode, dbus}, {1'b1, e_mode[i], e_bus[i]});
        4: chk("R7 quant byte", {dvalid, dmode, dbus}, {1'b1, e_mode[i], e_bus[i]});
        default: chk("R8 vector byte", {dvalid, dmode, dbus}, {1'b1, e_mode[i], e_bus[i]});
      endcase
      if (i < n - 1) chk("R10 busy mid header", ready, 0);
      @(negedge clk);
      start = 1'b0;
    end
    #1;
    chk_idle("R8 R10 idle after last byte");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_idle("R1 after reset");
    for (int i = 0; i < NVEC; i++) run_mb(VEC[i], 1'b0, 1'b0);
    // R9 stall inside header, with and without vectors
    run_mb(VEC[0], 1'b1, 1'b0);
    run_mb(VEC[1], 1'b1, 1'b0);
    // R10 start while busy ignored
    run_mb(VEC[4], 1'b0, 1'b1);
    run_mb(VEC[2], 1'b0, 1'b1);
    // R9 dready low while idle
    @(negedge clk); dready = 1'b0; #1;
    chk_idle("R9 R1 idle with dready low");
    dready = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule